// File: doc/BRIEF.md
# Ring-of-Cells Rereading Buffer

This block passes a stream of data items from a writer to a reader through a ring of identical storage cells. No cell holds a global index. Each cell keeps one stored item and two single-bit ownership flags, one for the writer and one for the reader. A cell talks only to its two neighbours: it reads their flags, and it hands a pointer on through a request/acknowledge pair. To make the buffer deeper, add cells to the ring. No shared multiplexer index grows with the depth.

The writer and the reader each run a four-phase handshake at the block edge: raise the request, wait for the acknowledge, drop the request, and see the acknowledge fall.

- **Writer side.** The writer never overwrites. Once it has filled its cell, it holds there until the following cell is free of the reader. A new write is therefore stalled whenever every other cell still holds unread data.
- **Reader side.** The reader never waits for new data. If the following cell still belongs to the writer, the reader rereads the item it already holds.

All of this runs in a single clock domain.

Top module: `cellring_rrbuf`

## Requirements
- R1: After reset, wr_ack and rd_ack are low, the reader owns cell 0 and the writer owns cell 1, and every cell holds zero. A read issued straight after reset therefore returns zero.
- R2: While wr_req is high, the cell that owns the writer flag captures wr_data and raises wr_ack. wr_ack then stays high until wr_req is low.
- R3: After a cell has been written, the writer flag moves to the following cell only once that cell does not hold the reader flag. Until then, a new write request gets no wr_ack.
- R4: On rd_req, if the cell after the reader does not hold the writer flag, the reader flag moves to that cell and rd_data shows its item. Items come back in the order they were written, none skipped.
- R5: On rd_req, if the cell after the reader holds the writer flag, the reader stays where it is and rd_data repeats the item it last returned.
- R6: rd_ack rises only in answer to rd_req. It stays high with rd_data unchanged until rd_req is low, and then falls.
- R7: With N_CELLS cells, exactly N_CELLS-1 writes are acknowledged after reset with no read. The next write is stalled.
- R8: Exactly one writer flag and exactly one reader flag are set at all times, never in the same cell. A cell without a flag ignores external requests, so only one cell drives each acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | Write request, four-phase |
| wr_data | input | DATA_W | Item to write |
| wr_ack | output | 1 | Write acknowledge |
| rd_req | input | 1 | Read request, four-phase |
| rd_ack | output | 1 | Read acknowledge |
| rd_data | output | DATA_W | Item read, valid while rd_ack is high |

## Verification
A directed opening runs on a three-cell ring, issuing one operation type at a time:
- A read on the empty ring tells a reread apart from an advance.
- A burst of writes with no reads tells a correct capacity stall apart from overwriting or an early stall.
- Reads that drain the ring confirm that a stalled writer resumes only after the reader leaves the following cell.

A pseudo-random mix of reads and writes then follows. It exercises hand-offs that happen while the other side is mid-handshake. A reference ring model predicts, for every operation, whether it advances, rereads or stalls, and which item it returns.

// File: rtl/crb_pkg.sv
package crb_pkg;

   typedef enum logic [1:0] {
      WS_IDLE  = 2'd0,
      WS_READY = 2'd1,
      WS_ACK   = 2'd2,
      WS_HOLD  = 2'd3
   } wside_e;

   typedef enum logic [1:0] {
      RS_IDLE  = 2'd0,
      RS_READY = 2'd1,
      RS_ACK   = 2'd2
   } rside_e;

endpackage

// File: rtl/crb_wr_ctl.sv
module crb_wr_ctl
   import crb_pkg::*;
#(
   parameter bit OWNS_AT_RESET = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_req,
   input  logic from_prev_req,
   output logic to_prev_ack,
   input  logic next_has_rd,
   output logic to_next_req,
   input  logic from_next_ack,
   output logic capture,
   output logic owns_w,
   output logic ack
);

   wside_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         WS_IDLE:  if (from_prev_req) st_d = WS_READY;
         WS_READY: if (wr_req)        st_d = WS_ACK;
         WS_ACK:   if (!wr_req)       st_d = WS_HOLD;
         WS_HOLD:  if (from_next_ack) st_d = WS_IDLE;
         default:                     st_d = WS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= OWNS_AT_RESET ? WS_READY : WS_IDLE;
      else        st_q <= st_d;
   end

   assign capture     = (st_q == WS_READY) && wr_req;
   assign ack         = (st_q == WS_ACK);
   assign owns_w      = (st_q != WS_IDLE);
   assign to_next_req = (st_q == WS_HOLD) && !next_has_rd;
   assign to_prev_ack = (st_q == WS_IDLE) && from_prev_req;

endmodule

// File: rtl/crb_rd_ctl.sv
module crb_rd_ctl
   import crb_pkg::*;
#(
   parameter bit OWNS_AT_RESET = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_req,
   input  logic from_prev_req,
   output logic to_prev_ack,
   input  logic next_has_wr,
   output logic to_next_req,
   input  logic from_next_ack,
   output logic owns_r,
   output logic ack
);

   rside_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         RS_IDLE:  if (from_prev_req) st_d = RS_ACK;
         RS_READY: begin
            if (rd_req) begin
               if (next_has_wr)        st_d = RS_ACK;
               else if (from_next_ack) st_d = RS_IDLE;
            end
         end
         RS_ACK:   if (!rd_req) st_d = RS_READY;
         default:               st_d = RS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= OWNS_AT_RESET ? RS_READY : RS_IDLE;
      else        st_q <= st_d;
   end

   assign to_next_req = (st_q == RS_READY) && rd_req && !next_has_wr;
   assign to_prev_ack = (st_q == RS_IDLE) && from_prev_req;
   assign owns_r      = (st_q != RS_IDLE);
   assign ack         = (st_q == RS_ACK);

endmodule

// File: rtl/crb_cell.sv
module crb_cell #(
   parameter int DATA_W     = 8,
   parameter bit W_AT_RESET = 1'b0,
   parameter bit R_AT_RESET = 1'b0,
   parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_req,
   input  logic              w_prev_req,
   output logic              w_prev_ack,
   output logic              w_next_req,
   input  logic              w_next_ack,
   input  logic              r_prev_req,
   output logic              r_prev_ack,
   output logic              r_next_req,
   input  logic              r_next_ack,
   input  logic              next_w,
   input  logic              next_r,
   output logic              w_flag,
   output logic              r_flag,
   output logic              w_ack,
   output logic              r_ack,
   output logic [DATA_W-1:0] item
);

   logic              cap;
   logic [DATA_W-1:0] item_q;

   crb_wr_ctl #(.OWNS_AT_RESET(W_AT_RESET)) u_wr (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_req        (wr_req),
      .from_prev_req (w_prev_req),
      .to_prev_ack   (w_prev_ack),
      .next_has_rd   (next_r),
      .to_next_req   (w_next_req),
      .from_next_ack (w_next_ack),
      .capture       (cap),
      .owns_w        (w_flag),
      .ack           (w_ack)
   );

   crb_rd_ctl #(.OWNS_AT_RESET(R_AT_RESET)) u_rd (
      .clk           (clk),
      .rst_n         (rst_n),
      .rd_req        (rd_req),
      .from_prev_req (r_prev_req),
      .to_prev_ack   (r_prev_ack),
      .next_has_wr   (next_w),
      .to_next_req   (r_next_req),
      .from_next_ack (r_next_ack),
      .owns_r        (r_flag),
      .ack           (r_ack)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)   item_q <= INIT_VAL;
      else if (cap) item_q <= wr_data;
   end

   assign item = item_q;

endmodule

// File: rtl/cellring_rrbuf.sv
module cellring_rrbuf #(
   parameter int N_CELLS = 4,
   parameter int DATA_W  = 8,
   parameter int R_START = 0,
   parameter logic [DATA_W-1:0] INIT_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ack,
   input  logic              rd_req,
   output logic              rd_ack,
   output logic [DATA_W-1:0] rd_data
);

   localparam int W_START = (R_START + 1) % N_CELLS;

   if (N_CELLS < 3) begin : g_bad_depth
      $error("cellring_rrbuf: N_CELLS must be at least 3");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("cellring_rrbuf: DATA_W must be at least 1");
   end
   if (R_START < 0 || R_START >= N_CELLS) begin : g_bad_start
      $error("cellring_rrbuf: R_START out of range");
   end

   logic [N_CELLS-1:0] w_vec, r_vec;
   logic [N_CELLS-1:0] w_ack_vec, r_ack_vec;
   logic [N_CELLS-1:0] w_req_fwd, w_ack_bwd;
   logic [N_CELLS-1:0] r_req_fwd, r_ack_bwd;
   logic [DATA_W-1:0]  item_arr [N_CELLS];

   for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
      localparam int NXT = (i + 1) % N_CELLS;
      localparam int PRV = (i + N_CELLS - 1) % N_CELLS;
      crb_cell #(
         .DATA_W     (DATA_W),
         .W_AT_RESET (i == W_START),
         .R_AT_RESET (i == R_START),
         .INIT_VAL   (INIT_VAL)
      ) u_cell (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_req     (wr_req),
         .wr_data    (wr_data),
         .rd_req     (rd_req),
         .w_prev_req (w_req_fwd[PRV]),
         .w_prev_ack (w_ack_bwd[i]),
         .w_next_req (w_req_fwd[i]),
         .w_next_ack (w_ack_bwd[NXT]),
         .r_prev_req (r_req_fwd[PRV]),
         .r_prev_ack (r_ack_bwd[i]),
         .r_next_req (r_req_fwd[i]),
         .r_next_ack (r_ack_bwd[NXT]),
         .next_w     (w_vec[NXT]),
         .next_r     (r_vec[NXT]),
         .w_flag     (w_vec[i]),
         .r_flag     (r_vec[i]),
         .w_ack      (w_ack_vec[i]),
         .r_ack      (r_ack_vec[i]),
         .item       (item_arr[i])
      );
   end

   assign wr_ack = |w_ack_vec;
   assign rd_ack = |r_ack_vec;

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < N_CELLS; i++) begin
         if (r_ack_vec[i]) rd_data = rd_data | item_arr[i];
      end
   end

endmodule

// File: rtl/crb_checker.sv
module crb_checker #(
   parameter int N_CELLS = 4,
   parameter int DATA_W  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_req,
   input logic               wr_ack,
   input logic               rd_req,
   input logic               rd_ack,
   input logic [DATA_W-1:0]  rd_data,
   input logic [N_CELLS-1:0] w_vec,
   input logic [N_CELLS-1:0] r_vec
);

   a_r8_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(w_vec) == 1);

   a_r8_one_reader: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(r_vec) == 1);

   a_r8_flags_apart: assert property (@(posedge clk) disable iff (!rst_n)
      (w_vec & r_vec) == '0);

   a_r2_wack_held: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ack && wr_req |=> wr_ack);

   a_r2_wack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_ack) |-> $past(wr_req));

   a_r6_rack_held: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ack && rd_req |=> rd_ack && $stable(rd_data));

   a_r6_rack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_ack) |-> $past(rd_req));

   a_r6_rack_falls: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ack && !rd_req |=> !rd_ack);

endmodule

bind cellring_rrbuf crb_checker #(.N_CELLS(N_CELLS), .DATA_W(DATA_W)) u_crb_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_req  (wr_req),
   .wr_ack  (wr_ack),
   .rd_req  (rd_req),
   .rd_ack  (rd_ack),
   .rd_data (rd_data),
   .w_vec   (w_vec),
   .r_vec   (r_vec)
);

// File: tb/cellring_rrbuf_test.sv
module cellring_rrbuf_test;

   localparam int N  = 3;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_req = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          wr_ack;
   logic          rd_req = 1'b0;
   logic          rd_ack;
   logic [DW-1:0] rd_data;

   int n_cmp = 0;
   int n_bad = 0;

   logic [DW-1:0] exp_q [$];
   string         tag_q [$];
   logic          prev_rack = 1'b0;

   // reference ring model
   logic [DW-1:0] mdl_mem [N];
   int  wp = 1;
   int  rp = 0;
   bit  wfull = 0;
   int unsigned seed = 32'h1234_5678;

   always #4 clk = ~clk;

   cellring_rrbuf #(.N_CELLS(N), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_data), .wr_ack(wr_ack),
      .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data)
   );

   function automatic int nx(input int i);
      return (i + 1) % N;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic settle_model();
      if (wfull && rp != nx(wp)) begin
         wp = nx(wp);
         wfull = 0;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_write(input logic [DW-1:0] d);
      bit stall_exp;
      bit seen;
      stall_exp = wfull;
      seen = 0;
      @(negedge clk);
      wr_data = d;
      wr_req  = 1'b1;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (wr_ack) begin
            seen = 1;
            break;
         end
      end
      if (stall_exp) begin
         check(!seen, "R3 write stalled while next cell holds reader", seen, 0);
      end else begin
         check(seen, "R2 write acknowledged", seen, 1);
         if (seen) begin
            @(negedge clk);
            check(wr_ack, "R2 ack held while request high", wr_ack, 1);
         end
         mdl_mem[wp] = d;
         wfull = 1;
      end
      wr_req = 1'b0;
      for (int k = 0; k < 12 && wr_ack; k++) @(negedge clk);
      check(!wr_ack, "R2 ack released after request drop", wr_ack, 0);
      idle(4);
      settle_model();
   endtask

   task automatic do_read();
      bit seen;
      logic [DW-1:0] first;
      seen = 0;
      if (nx(rp) != wp) begin
         rp = nx(rp);
         tag_q.push_back("R4 advance R8");
      end else begin
         tag_q.push_back("R5 reread R8");
      end
      exp_q.push_back(mdl_mem[rp]);
      @(negedge clk);
      rd_req = 1'b1;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (rd_ack) begin
            seen = 1;
            break;
         end
      end
      check(seen, "R6 read acknowledged", seen, 1);
      first = rd_data;
      idle(2);
      check(rd_ack && rd_data == first, "R6 data held while request high", rd_data, first);
      rd_req = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(!rd_ack, "R6 ack falls after request drop", rd_ack, 0);
      idle(4);
      settle_model();
   endtask

   // monitor: compare each read item against the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (rd_ack && !prev_rack) begin
            if (exp_q.size() == 0) begin
               check(0, "R6 unexpected read ack", 1, 0);
            end else begin
               logic [DW-1:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(rd_data == e, t, rd_data, e);
            end
         end
         prev_rack = rd_ack;
      end
   end

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      for (int i = 0; i < N; i++) mdl_mem[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!wr_ack, "R1 wr_ack low after reset", wr_ack, 0);
      check(!rd_ack, "R1 rd_ack low after reset", rd_ack, 0);

      // R1/R5: read on fresh ring rereads the zero in cell 0
      do_read();

      // R7: N-1 writes accepted, then stall
      do_write(8'h11);
      do_write(8'h22);
      check(wfull && wp == N - 1, "R7 capacity reached after N-1 writes", wp, N - 1);
      do_write(8'h33);

      // drain and let writer resume
      do_read();
      do_write(8'h33);
      do_read();
      do_read();
      do_read();
      do_write(8'h44);
      do_read();
      do_read();

      // mixed traffic
      for (int it = 0; it < 80; it++) begin
         seed = seed * 32'd1103515245 + 32'd12345;
         if (seed[16]) do_write(DW'(seed[31:24]));
         else          do_read();
      end
      idle(10);
      check(exp_q.size() == 0, "R4 all reads returned", exp_q.size(), 0);
      finish_run();
   end

endmodule